// File: doc/BRIEF.md
# Serial EEPROM Transaction Controller

This block is the memory-access layer of a two-wire serial EEPROM slave. A byte-level bus front end, outside this block, reports bus START and STOP, hands over each received byte with a strobe, and reports the master's acknowledge after each byte the slave has sent. The controller decides whether each received byte is acknowledged. It supplies the next byte to send, and it owns the 512-byte storage array.

The array is seen as two banks of 256 bytes. An external active-page input picks the bank that the 8-bit byte address reaches. Write data is collected in a 16-byte page buffer and is only committed after STOP, during a write cycle of fixed length. While that cycle runs, the slave address is refused, so a master can poll for completion. Four block-protect inputs each guard one half of one bank.

Top module: `eep_txn_ctrl`

## Requirements
- R1: After reset no acknowledge strobe, transmit strobe or busy flag is active, the current address is 0x00, and every array byte reads 0xFF.
- R2: A byte received right after START is acknowledged only when its upper seven bits equal DEV_ADDR (0x50) and no write cycle is running. Bit 0 set means read and clear means write. A refused address makes every further byte and master acknowledge be ignored (no strobe at all) until the next START.
- R3: In a write, the byte after the write-mode address is always acknowledged and loads the current address. Each data byte is acknowledged and, after STOP, appears in the array at its address.
- R4: Within a write, the current address advances only in its low four bits, so data wraps inside the aligned 16-byte page. A 17th or later byte replaces the byte held for the same page slot.
- R5: A STOP that ends a write holding at least one accepted data byte raises the busy output on the following cycle for exactly TWR_CYCLES cycles. While busy, the slave address is answered with NoACK.
- R6: A START that arrives before STOP during the data phase discards the buffered bytes: no write cycle starts and the array is unchanged.
- R7: A read-mode address with no address phase returns, on the transmit strobe one cycle after the byte strobe, the byte at the current address. The current address then advances by one.
- R8: A selective read (write-mode address, byte address, repeated START, read-mode address) returns the byte at the given address first.
- R9: Each master ACK during a read produces the next byte one cycle later, and the address wraps from 0xFF to 0x00 within the bank. A master NoACK produces no further byte.
- R10: active_page = 0 reaches array bytes 0x000-0x0FF and 1 reaches 0x100-0x1FF. A write uses the bank sampled at its byte-address phase, and a read uses the bank present when each byte is loaded.
- R11: Protect bit index = 2*bank + address bit 7. When that bit is set, the data bytes of a write are answered with NoACK and are not stored. No write cycle starts, though the byte address is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | START or repeated START seen (one-cycle strobe) |
| bus_stop | input | 1 | STOP seen (one-cycle strobe) |
| rx_stb | input | 1 | A byte was received |
| rx_byte | input | 8 | Received byte |
| mack_stb | input | 1 | Master acknowledge phase after a sent byte |
| mack_ack | input | 1 | 1 = master ACK, 0 = master NoACK |
| active_page | input | 1 | Bank visible to the byte address |
| wp_blk | input | 4 | Per-block write protect |
| ack_stb | output | 1 | Acknowledge decision valid |
| ack_ok | output | 1 | 1 = ACK, 0 = NoACK |
| tx_stb | output | 1 | New byte to transmit |
| tx_byte | output | 8 | Byte to transmit |
| wr_busy | output | 1 | Internal write cycle running |

## Verification
The hardest state to reach from the ports is a write cycle whose page buffer has been overrun and wrapped. In that state, slot contents no longer follow arrival order, and a master polls while the commit is still running. Directed writes of 18 bytes and writes that start near the end of a page create it. A poll issued right after STOP checks the refusal. Random writes of 1 to 20 bytes at random offsets, in both banks, mix overrun and partial pages. A bench model of the page slots, the array and the current address then checks every read-back.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLV,
    ST_BADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } txn_st_t;

  // next address inside an aligned page of 2**pw bytes
  function automatic logic [BYTE_W-1:0] addr_in_page(input logic [BYTE_W-1:0] a,
                                                     input int unsigned pw);
    logic [BYTE_W-1:0] m;
    logic [BYTE_W-1:0] inc;
    m   = BYTE_W'((1 << pw) - 1);
    inc = a + BYTE_W'(1);
    return (a & ~m) | (inc & m);
  endfunction

  // next address for reads: full 8-bit wrap
  function automatic logic [BYTE_W-1:0] addr_seq(input logic [BYTE_W-1:0] a);
    return a + BYTE_W'(1);
  endfunction

  // protect block index: bank in the upper bit, address half in the lower
  function automatic logic [1:0] blk_of(input logic bank, input logic [BYTE_W-1:0] a);
    return {bank, a[BYTE_W-1]};
  endfunction
endpackage

// File: rtl/eep_store.sv
module eep_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
  parameter int SW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd_slot,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          any_valid
);
  localparam int SLOTS = 1 << SW;

  logic [SLOTS-1:0][DW-1:0] dat_w;
  logic [SLOTS-1:0]         vld_w;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DW-1:0] d_q;
    logic          v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (clr) begin
        v_q <= 1'b0;
      end else if (wr_en && wr_slot == SW'(g)) begin
        d_q <= wr_data;
        v_q <= 1'b1;
      end
    end
    assign dat_w[g] = d_q;
    assign vld_w[g] = v_q;
  end

  assign rd_data   = dat_w[rd_slot];
  assign rd_valid  = vld_w[rd_slot];
  assign any_valid = |vld_w;
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
  parameter int TWR = 40,  // must exceed 2**SW so every slot is visited
  parameter int SW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic [SW-1:0] slot_idx,
  output logic          slot_en
);
  localparam int SLOTS = 1 << SW;
  localparam int CW    = $clog2(TWR + 1);

  logic [CW-1:0] cnt;
  logic [SW:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
    end else if (go && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(TWR - 1);
      idx  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
      if (idx != (SW+1)'(SLOTS)) idx <= idx + (SW+1)'(1);
    end
  end

  assign slot_idx = idx[SW-1:0];
  assign slot_en  = busy && !idx[SW];
endmodule

// File: rtl/eep_txn_ctrl.sv
module eep_txn_ctrl
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         PAGE_W     = 4,
  parameter int         TWR_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_start,
  input  logic        bus_stop,
  input  logic        rx_stb,
  input  logic [7:0]  rx_byte,
  input  logic        mack_stb,
  input  logic        mack_ack,
  input  logic        active_page,
  input  logic [3:0]  wp_blk,
  output logic        ack_stb,
  output logic        ack_ok,
  output logic        tx_stb,
  output logic [7:0]  tx_byte,
  output logic        wr_busy
);
  localparam int AW    = BYTE_W + 1;
  localparam int ROW_W = AW - PAGE_W;

  txn_st_t            st;
  logic [BYTE_W-1:0]  cur;
  logic               bank_w;
  logic [ROW_W-1:0]   wr_row;

  // named internal events
  logic ev_slv, ev_badr, ev_wdat, ev_rnext, ev_rend;
  logic slv_hit, prot_hit, rd_load, buf_clr, cmt_go;

  logic [7:0]        rd_data;
  logic [7:0]        pb_data;
  logic              pb_valid, pb_any;
  logic [PAGE_W-1:0] cm_idx;
  logic              cm_en;
  logic              mem_we;

  assign ev_slv   = rx_stb && st == ST_SLV;
  assign ev_badr  = rx_stb && st == ST_BADDR;
  assign ev_wdat  = rx_stb && st == ST_WDATA;
  assign ev_rnext = mack_stb && mack_ack && st == ST_RDATA;
  assign ev_rend  = mack_stb && !mack_ack && st == ST_RDATA;
  assign slv_hit  = rx_byte[7:1] == DEV_ADDR && !wr_busy;
  assign prot_hit = wp_blk[blk_of(bank_w, cur)];
  assign rd_load  = (ev_slv && slv_hit && rx_byte[0]) || ev_rnext;
  assign buf_clr  = ev_badr || (bus_start && st == ST_WDATA);
  assign cmt_go   = bus_stop && st == ST_WDATA && pb_any;
  assign mem_we   = cm_en && pb_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else if (bus_start) begin
      st <= ST_SLV;
    end else if (bus_stop) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_SLV:   if (rx_stb) st <= !slv_hit ? ST_SKIP : (rx_byte[0] ? ST_RDATA : ST_BADDR);
        ST_BADDR: if (rx_stb) st <= ST_WDATA;
        ST_RDATA: if (ev_rend) st <= ST_SKIP;
        default:  st <= st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_stb <= 1'b0;
      ack_ok  <= 1'b0;
      tx_stb  <= 1'b0;
      tx_byte <= '0;
      cur     <= '0;
      bank_w  <= 1'b0;
      wr_row  <= '0;
    end else begin
      ack_stb <= ev_slv || ev_badr || ev_wdat;
      ack_ok  <= ev_slv ? slv_hit : (ev_badr ? 1'b1 : (ev_wdat && !prot_hit));
      tx_stb  <= rd_load;
      if (rd_load) tx_byte <= rd_data;
      if (ev_badr)      cur <= rx_byte;
      else if (ev_wdat) cur <= addr_in_page(cur, PAGE_W);
      else if (rd_load) cur <= addr_seq(cur);
      if (ev_badr) bank_w <= active_page;
      if (cmt_go)  wr_row <= {bank_w, cur[BYTE_W-1:PAGE_W]};
    end
  end

  eep_pagebuf #(.SW(PAGE_W), .DW(BYTE_W)) u_pbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (buf_clr),
    .wr_en    (ev_wdat && !prot_hit),
    .wr_slot  (cur[PAGE_W-1:0]),
    .wr_data  (rx_byte),
    .rd_slot  (cm_idx),
    .rd_data  (pb_data),
    .rd_valid (pb_valid),
    .any_valid(pb_any)
  );

  eep_wcycle #(.TWR(TWR_CYCLES), .SW(PAGE_W)) u_wcyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (cmt_go),
    .busy    (wr_busy),
    .slot_idx(cm_idx),
    .slot_en (cm_en)
  );

  eep_store #(.AW(AW), .DW(BYTE_W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .waddr({wr_row, cm_idx}),
    .wdata(pb_data),
    .raddr({active_page, cur}),
    .rdata(rd_data)
  );

  // R2: wrong slave address is refused
  a_r2_foreign_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_slv && rx_byte[7:1] != DEV_ADDR) |=> (ack_stb && !ack_ok));

  // R4: page bits of the address hold across a data byte
  a_r4_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdat |=> cur[BYTE_W-1:PAGE_W] == $past(cur[BYTE_W-1:PAGE_W]));

  // R5: polling during the write cycle is refused
  a_r5_poll_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_slv && wr_busy) |=> (ack_stb && !ack_ok));

  // R5: a commit never starts on top of a running cycle
  a_r5_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_go |-> !wr_busy);

  // R6: the page buffer is never cleared under a running commit
  a_r6_clr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |-> !wr_busy);

  // R9: master ACK yields the next byte
  a_r9_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rnext |=> tx_stb);

  // R11: protected data bytes get NoACK
  a_r11_prot_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdat && prot_hit) |=> (ack_stb && !ack_ok));
endmodule

// File: tb/tb_eep_txn_ctrl.sv
module tb_eep_txn_ctrl;
  localparam int TWR = 40;
  localparam logic [6:0] SA = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 0, bus_stop = 0, rx_stb = 0, mack_stb = 0, mack_ack = 0;
  logic [7:0] rx_byte = '0;
  logic active_page = 0;
  logic [3:0] wp_blk = '0;
  logic ack_stb, ack_ok, tx_stb, wr_busy;
  logic [7:0] tx_byte;

  always #2.5 clk = ~clk;

  eep_txn_ctrl #(.DEV_ADDR(SA), .PAGE_W(4), .TWR_CYCLES(TWR)) dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .mack_stb(mack_stb), .mack_ack(mack_ack),
    .active_page(active_page), .wp_blk(wp_blk), .ack_stb(ack_stb), .ack_ok(ack_ok),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .wr_busy(wr_busy));

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] mdl [512];
  logic [7:0] mcur = 8'h00;
  logic [7:0] wdat [32];

  function automatic logic [7:0] nxt_page(input logic [7:0] a);
    return {a[7:4], 4'(a[3:0] + 4'd1)};
  endfunction
  function automatic logic [7:0] nxt_seq(input logic [7:0] a);
    return 8'(a + 8'd1);
  endfunction
  function automatic logic is_prot(input logic bank, input logic [7:0] a);
    return wp_blk[{bank, a[7]}];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic ev_start_t();
    bus_start = 1; @(negedge clk); bus_start = 0; @(negedge clk);
  endtask
  task automatic ev_stop_t();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic put(input logic [7:0] b, output logic av, output logic ok,
                     output logic tv, output logic [7:0] td);
    rx_byte = b; rx_stb = 1; @(negedge clk); rx_stb = 0;
    av = ack_stb; ok = ack_ok; tv = tx_stb; td = tx_byte;
    @(negedge clk);
  endtask
  task automatic mack(input logic a, output logic tv, output logic [7:0] td);
    mack_ack = a; mack_stb = 1; @(negedge clk); mack_stb = 0;
    tv = tx_stb; td = tx_byte;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (wr_busy && g < 1000) begin g++; @(negedge clk); end
  endtask

  // write n bytes of wdat at address a in bank; poll = issue an address during busy
  task automatic do_write(input string tag, input logic bank, input logic [7:0] a,
                          input int n, input bit poll);
    logic av, ok, tv; logic [7:0] td;
    logic [7:0] sd [16]; bit sv [16]; bit any = 0; bit pr;
    int c;
    for (int i = 0; i < 16; i++) sv[i] = 0;
    active_page = bank;
    ev_start_t();
    put({SA, 1'b0}, av, ok, tv, td);
    chk({tag, " R2 wr addr ack"}, {av, ok}, 2'b11);
    put(a, av, ok, tv, td);
    chk({tag, " R3 baddr ack"}, {av, ok}, 2'b11);
    mcur = a;
    pr = is_prot(bank, a);
    for (int i = 0; i < n; i++) begin
      put(wdat[i], av, ok, tv, td);
      chk({tag, pr ? " R11 data nack" : " R3 data ack"}, {av, ok}, {1'b1, !pr});
      if (!pr) begin sd[mcur[3:0]] = wdat[i]; sv[mcur[3:0]] = 1; any = 1; end
      mcur = nxt_page(mcur);
    end
    ev_stop_t();
    chk({tag, " R5 busy after stop"}, wr_busy, any);
    if (any) begin
      for (int i = 0; i < 16; i++)
        if (sv[i]) mdl[{bank, a[7:4], 4'(i)}] = sd[i];
      if (poll) begin
        ev_start_t();
        put({SA, 1'b0}, av, ok, tv, td);
        chk({tag, " R5 poll nack"}, {av, ok}, 2'b10);
        ev_stop_t();
        wait_idle();
      end else begin
        c = 0;
        while (wr_busy && c < 1000) begin c++; @(negedge clk); end
        chk({tag, " R5 busy length"}, c, TWR);
      end
    end
    @(negedge clk);
  endtask

  task automatic do_read(input string tag, input logic bank, input bit sel,
                         input logic [7:0] a, input int n);
    logic av, ok, tv; logic [7:0] td;
    active_page = bank;
    if (sel) begin
      ev_start_t();
      put({SA, 1'b0}, av, ok, tv, td);
      put(a, av, ok, tv, td);
      chk({tag, " R8 baddr ack"}, {av, ok}, 2'b11);
      mcur = a;
    end
    ev_start_t();
    put({SA, 1'b1}, av, ok, tv, td);
    chk({tag, " R2 rd addr ack"}, {av, ok}, 2'b11);
    chk({tag, sel ? " R8 first byte" : " R7 first byte"}, {tv, td}, {1'b1, mdl[{bank, mcur}]});
    mcur = nxt_seq(mcur);
    for (int i = 1; i < n; i++) begin
      mack(1'b1, tv, td);
      chk({tag, bank ? " R10 seq byte" : " R9 seq byte"}, {tv, td}, {1'b1, mdl[{bank, mcur}]});
      mcur = nxt_seq(mcur);
    end
    mack(1'b0, tv, td);
    chk({tag, " R9 no byte after nack"}, tv, 1'b0);
    ev_stop_t();
    @(negedge clk);
  endtask

  initial begin
    logic av, ok, tv; logic [7:0] td;
    void'($urandom(32'd7321));
    for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack_stb idle", ack_stb, 1'b0);
    chk("R1 tx_stb idle", tx_stb, 1'b0);
    chk("R1 busy idle", wr_busy, 1'b0);
    do_read("R1 R7 imm after reset", 1'b0, 1'b0, 8'h00, 2);

    // R3 basic page write and selective read back
    for (int i = 0; i < 3; i++) wdat[i] = 8'h11 * 8'(i + 1);
    do_write("R3 basic", 1'b0, 8'h10, 3, 1'b0);
    do_read("R3 readback", 1'b0, 1'b1, 8'h10, 3);

    // R5 poll during the write cycle
    wdat[0] = 8'h5A;
    do_write("R5 poll", 1'b0, 8'h44, 1, 1'b1);
    do_read("R5 after poll", 1'b0, 1'b1, 8'h44, 1);

    // R4 wrap inside page and overrun
    for (int i = 0; i < 4; i++) wdat[i] = 8'hC0 + 8'(i);
    do_write("R4 wrap", 1'b0, 8'h2E, 4, 1'b0);
    do_read("R4 wrap rd", 1'b0, 1'b1, 8'h20, 16);
    for (int i = 0; i < 18; i++) wdat[i] = 8'(i * 7 + 3);
    do_write("R4 overrun", 1'b0, 8'h30, 18, 1'b0);
    do_read("R4 overrun rd", 1'b0, 1'b1, 8'h30, 16);

    // R6 repeated START discards the buffered data
    active_page = 0;
    ev_start_t();
    put({SA, 1'b0}, av, ok, tv, td);
    put(8'h50, av, ok, tv, td);
    put(8'hAA, av, ok, tv, td);
    ev_start_t();
    ev_stop_t();
    chk("R6 no busy after discard", wr_busy, 1'b0);
    @(negedge clk);
    do_read("R6 unchanged", 1'b0, 1'b1, 8'h50, 1);

    // R9 sequential wrap 0xFF -> 0x00
    do_read("R9 wrap", 1'b0, 1'b1, 8'hFE, 4);

    // R10 bank selection
    wdat[0] = 8'h3C; do_write("R10 bank1 wr", 1'b1, 8'h10, 1, 1'b0);
    do_read("R10 bank1 rd", 1'b1, 1'b1, 8'h10, 1);
    do_read("R10 bank0 rd", 1'b0, 1'b1, 8'h10, 1);

    // R11 protect: block 1 = bank 0 upper half
    wp_blk = 4'b0010;
    for (int i = 0; i < 3; i++) wdat[i] = 8'h77;
    do_write("R11 prot", 1'b0, 8'h90, 3, 1'b0);
    do_read("R11 unchanged", 1'b0, 1'b1, 8'h90, 3);
    wdat[0] = 8'h9E; do_write("R11 other block", 1'b0, 8'h20, 1, 1'b0);
    wp_blk = 4'b0000;

    // R2 foreign address ignored to next START
    ev_start_t();
    put({7'h51, 1'b0}, av, ok, tv, td);
    chk("R2 foreign nack", {av, ok}, 2'b10);
    put(8'h00, av, ok, tv, td);
    chk("R2 ignored byte", av, 1'b0);
    mack(1'b1, tv, td);
    chk("R2 ignored mack", tv, 1'b0);
    ev_stop_t();
    @(negedge clk);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op; logic bk; logic [7:0] ad; int n;
      op = $urandom_range(0, 2);
      bk = 1'($urandom_range(0, 1));
      ad = 8'($urandom_range(0, 255));
      if (op == 0) begin
        n = $urandom_range(1, 20);
        for (int i = 0; i < n; i++) wdat[i] = 8'($urandom_range(0, 255));
        do_write("R4 rnd wr", bk, ad, n, it[0]);
      end else if (op == 1) begin
        do_read("R8 rnd sel", bk, 1'b1, ad, $urandom_range(1, 5));
      end else begin
        do_read("R7 rnd imm", bk, 1'b0, 8'h00, $urandom_range(1, 4));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog got hang exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule